// File: doc/BRIEF.md
# Bit-Serial Shift-Register Adder

This block adds two unsigned operands of `WIDTH` bits using one full adder. The two operands sit in two right-shifting registers. The least significant bits of both registers, together with a stored carry, feed the single full adder.

On every enabled clock, both registers move one place toward the LSB, and the carry flip-flop takes the new carry. The sum bit enters the top of the first register, so after `WIDTH` enabled clocks that register holds the result. The second register takes its new top bit from an external serial pin, so the next operand can be streamed in while the current one is used up.

A parallel load writes both operands and starts a new addition. A synchronous clear empties everything. A one-cycle done pulse marks the end of each group of `WIDTH` shifts, and the final carry is presented as carry-out.

Top module: `serial_adder_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `acc_o`, `addend_o`, `carry_o` and `done_o` are all zero.
- R2: With `load_i` high and `clr_i` low, the next clock edge does four things: it copies `opa_i` into `acc_o`, copies `opb_i` into `addend_o`, clears `carry_o` and restarts the shift count.
- R3: With `shift_i` high and both `load_i` and `clr_i` low, each edge shifts both registers right by one place. The top bit of `acc_o` takes the value `sum_bit_o` had before the edge, and the top bit of `addend_o` takes `ser_b_i`.
- R4: `sum_bit_o` always equals `acc_o[0]` XOR `addend_o[0]` XOR `carry_o`. On a shift edge, `carry_o` takes the majority of those three bits.
- R5: With `clr_i`, `load_i` and `shift_i` all low, an edge changes none of `acc_o`, `addend_o` or `carry_o`, and `done_o` is low after it.
- R6: After a load of A and B followed by `WIDTH` shift edges, `acc_o` equals (A+B) mod 2^WIDTH and `carry_o` equals bit `WIDTH` of A+B.
- R7: `done_o` is high for exactly one cycle, right after the `WIDTH`-th shift edge since the last load or clear. It is never high at any other time.
- R8: `clr_i` is synchronous and has priority over `load_i` and `shift_i`. After a clear edge, all registers, the carry and the shift count are zero.
- R9: After `WIDTH` shifts, `addend_o` holds the bits that arrived on `ser_b_i`. The first bit received ends up at bit 0.
- R10: Cycles with no shift placed between shift edges do not change the result of R6 or the timing of the done pulse in R7, counted in shift edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all state |
| load_i | input | 1 | Parallel load of both operands |
| shift_i | input | 1 | Enables one serial add step |
| opa_i | input | WIDTH | Operand A for parallel load |
| opb_i | input | WIDTH | Operand B for parallel load |
| ser_b_i | input | 1 | Serial input into the top of register B |
| sum_bit_o | output | 1 | Combinational full-adder sum bit |
| acc_o | output | WIDTH | Register A contents (operand A, then the result) |
| addend_o | output | WIDTH | Register B contents |
| carry_o | output | 1 | Stored carry (the final carry-out once an add finishes) |
| done_o | output | 1 | One-cycle pulse after the WIDTH-th shift |

## Verification
Load, clear and each shift step show on the register outputs one edge after the control is sampled. The done pulse and the final sum appear together, right after the `WIDTH`-th shift edge. The bench drives inputs at falling edges and samples 2 ns after each rising edge. The monitor therefore reads the result on the same edge that raises `done_o`, before the driver can start the next load. Directed checks of load, clear, single shifts and the combinational sum bit are read at the falling edge that follows the edge in question.

// File: rtl/serial_adder_pkg.sv
package serial_adder_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_SHIFT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } sa_op_e;
endpackage

// File: rtl/serial_adder_shreg.sv
module serial_adder_shreg
    import serial_adder_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sa_op_e           op_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             ser_i,
    output logic [WIDTH-1:0] q_o
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
    } shreg_t;

    shreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (op_i)
            OP_CLEAR: st_d.data = '0;
            OP_LOAD:  st_d.data = par_i;
            OP_SHIFT: st_d.data = {ser_i, st_q.data[WIDTH-1:1]};
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.data;

    assert_shift_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_SHIFT |=> (q_o[WIDTH-2:0] == $past(q_o[WIDTH-1:1])) && (q_o[WIDTH-1] == $past(ser_i)));
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_HOLD |=> $stable(q_o));
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_CLEAR |=> q_o == '0);
    assert_load_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_LOAD |=> q_o == $past(par_i));
endmodule

// File: rtl/serial_adder_carry.sv
module serial_adder_carry
    import serial_adder_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sa_op_e op_i,
    input  logic   a_bit_i,
    input  logic   b_bit_i,
    output logic   sum_o,
    output logic   carry_o
);
    typedef struct packed {
        logic cy;
    } carry_t;

    carry_t st_d, st_q;
    logic   cy_next;

    always_comb begin
        sum_o   = a_bit_i ^ b_bit_i ^ st_q.cy;
        cy_next = (a_bit_i & b_bit_i) | (a_bit_i & st_q.cy) | (b_bit_i & st_q.cy);
        st_d    = st_q;
        unique case (op_i)
            OP_CLEAR, OP_LOAD: st_d.cy = 1'b0;
            OP_SHIFT:          st_d.cy = cy_next;
            default:           st_d    = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign carry_o = st_q.cy;

    assert_load_clears_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_LOAD || op_i == OP_CLEAR) |=> !carry_o);
    assert_carry_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_i == OP_HOLD |=> $stable(carry_o));
    assert_carry_needs_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == OP_SHIFT && !a_bit_i && !b_bit_i) |=> !carry_o);
endmodule

// File: rtl/serial_adder_counter.sv
module serial_adder_counter
    import serial_adder_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  sa_op_e op_i,
    output logic   done_o
);
    localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (op_i)
            OP_CLEAR, OP_LOAD: st_d.cnt = '0;
            OP_SHIFT: begin
                if (st_q.cnt == LAST) begin
                    st_d.cnt  = '0;
                    st_d.done = 1'b1;
                end else begin
                    st_d.cnt  = st_q.cnt + 1'b1;
                end
            end
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_after_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        op_i != OP_SHIFT |=> !done_o);
endmodule

// File: rtl/serial_adder_top.sv
module serial_adder_top
    import serial_adder_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic             shift_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic             ser_b_i,
    output logic             sum_bit_o,
    output logic [WIDTH-1:0] acc_o,
    output logic [WIDTH-1:0] addend_o,
    output logic             carry_o,
    output logic             done_o
);
    sa_op_e op;
    logic   sum_w;

    always_comb begin
        if (clr_i)        op = OP_CLEAR;
        else if (load_i)  op = OP_LOAD;
        else if (shift_i) op = OP_SHIFT;
        else              op = OP_HOLD;
    end

    serial_adder_shreg #(.WIDTH(WIDTH)) u_reg_a (
        .clk(clk), .rst_n(rst_n), .op_i(op), .par_i(opa_i), .ser_i(sum_w), .q_o(acc_o)
    );

    serial_adder_shreg #(.WIDTH(WIDTH)) u_reg_b (
        .clk(clk), .rst_n(rst_n), .op_i(op), .par_i(opb_i), .ser_i(ser_b_i), .q_o(addend_o)
    );

    serial_adder_carry u_carry (
        .clk(clk), .rst_n(rst_n), .op_i(op), .a_bit_i(acc_o[0]), .b_bit_i(addend_o[0]),
        .sum_o(sum_w), .carry_o(carry_o)
    );

    serial_adder_counter #(.WIDTH(WIDTH)) u_count (
        .clk(clk), .rst_n(rst_n), .op_i(op), .done_o(done_o)
    );

    assign sum_bit_o = sum_w;

    assert_sum_feedback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i && !clr_i) |=> acc_o[WIDTH-1] == $past(sum_bit_o));
    assert_clear_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_o == '0) && (addend_o == '0) && !carry_o && !done_o);
endmodule

// File: tb/serial_adder_top_tb_top.sv
`timescale 1ns/1ps
module serial_adder_top_tb_top;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_i = 1'b0, load_i = 1'b0, shift_i = 1'b0, ser_b_i = 1'b0;
    logic [W-1:0] opa_i = '0, opb_i = '0;
    logic sum_bit_o, carry_o, done_o;
    logic [W-1:0] acc_o, addend_o;

    always #4 clk = ~clk;

    serial_adder_top #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .load_i(load_i), .shift_i(shift_i),
        .opa_i(opa_i), .opb_i(opb_i), .ser_b_i(ser_b_i), .sum_bit_o(sum_bit_o),
        .acc_o(acc_o), .addend_o(addend_o), .carry_o(carry_o), .done_o(done_o)
    );

    typedef struct {
        logic [W-1:0] sum;
        logic         cout;
        logic [W-1:0] newb;
        string        tag;
    } exp_t;

    exp_t sb[$];
    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic [W-1:0] nb, input int gap, input string tag);
        logic [W:0] t;
        exp_t e;
        t = {1'b0, a} + {1'b0, b};
        e.sum = t[W-1:0]; e.cout = t[W]; e.newb = nb; e.tag = tag;
        @(negedge clk);
        load_i = 1'b1; opa_i = a; opb_i = b;
        sb.push_back(e);
        @(negedge clk);
        load_i = 1'b0;
        for (int i = 0; i < W; i++) begin
            shift_i = 1'b1; ser_b_i = nb[i];
            @(negedge clk);
            if (gap > 0) begin
                shift_i = 1'b0;
                repeat (gap) @(negedge clk);
            end
        end
        shift_i = 1'b0;
    endtask

    // Monitor: the result is due on the edge that raises done_o
    always begin
        @(posedge clk);
        #2;
        if (rst_n && done_o) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7 done with nothing pending", 64'(done_o), 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(acc_o == e.sum, {"R6 sum ", e.tag}, 64'(acc_o), 64'(e.sum));
                check(carry_o == e.cout, {"R6 carry-out ", e.tag}, 64'(carry_o), 64'(e.cout));
                check(addend_o == e.newb, {"R9 serial B ", e.tag}, 64'(addend_o), 64'(e.newb));
            end
        end
    end

    initial begin
        #(8 * 200000);
        check(1'b0, "watchdog expired", 64'd0, 64'd1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(acc_o == 0 && addend_o == 0 && !carry_o && !done_o, "R1 reset state",
              {acc_o, addend_o, carry_o, done_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(acc_o == 0 && !done_o, "R1 after reset release", 64'(acc_o), 64'd0);

        // R2 load and R4 sum bit
        load_i = 1'b1; opa_i = 8'h03; opb_i = 8'h01;
        @(negedge clk);
        load_i = 1'b0;
        check(acc_o == 8'h03 && addend_o == 8'h01 && !carry_o, "R2 load",
              {acc_o, addend_o, carry_o}, {8'h03, 8'h01, 1'b0});
        check(sum_bit_o == 1'b0, "R4 sum bit 1+1+0", 64'(sum_bit_o), 64'd0);
        // R3 one shift step: sum 0 into MSB, carry 1, ser_b 1 into MSB of B
        shift_i = 1'b1; ser_b_i = 1'b1;
        @(negedge clk);
        shift_i = 1'b0;
        check(acc_o == 8'h01, "R3 shift A", 64'(acc_o), 64'h01);
        check(addend_o == 8'h80, "R3 shift B", 64'(addend_o), 64'h80);
        check(carry_o == 1'b1, "R4 carry majority", 64'(carry_o), 64'd1);
        check(sum_bit_o == 1'b0, "R4 sum bit 1+0+1", 64'(sum_bit_o), 64'd0);
        // R5 hold
        repeat (2) @(negedge clk);
        check(acc_o == 8'h01 && addend_o == 8'h80 && carry_o && !done_o, "R5 hold",
              {acc_o, addend_o, carry_o}, {8'h01, 8'h80, 1'b1});
        // R8 clear beats load and shift
        clr_i = 1'b1; load_i = 1'b1; shift_i = 1'b1; opa_i = 8'hAA;
        @(negedge clk);
        clr_i = 1'b0; load_i = 1'b0; shift_i = 1'b0;
        check(acc_o == 0 && addend_o == 0 && !carry_o, "R8 clear priority",
              {acc_o, addend_o, carry_o}, 64'd0);
        // R8 count restarted: W-1 shifts give no done
        for (int i = 0; i < W - 1; i++) begin
            shift_i = 1'b1;
            @(negedge clk);
            check(!done_o, "R7 no early done", 64'(done_o), 64'd0);
        end
        shift_i = 1'b0;
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;

        // Corner cases
        run_add(8'hFF, 8'h01, 8'h5A, 0, "R6 wrap");
        run_add(8'hFF, 8'hFF, 8'hC3, 0, "R6 max");
        run_add(8'h00, 8'h00, 8'hFF, 0, "R6 zero");
        run_add(8'h7F, 8'h81, 8'h01, 2, "R10 gaps");
        // R5 result held while idle
        repeat (3) @(negedge clk);
        check(acc_o == 8'h00 && carry_o == 1'b1 && !done_o, "R5 result held",
              {acc_o, carry_o}, {8'h00, 1'b1});
        // Random operands
        for (int k = 0; k < 24; k++) begin
            run_add(W'($urandom), W'($urandom), W'($urandom), (k % 4 == 3) ? 1 : 0,
                    (k % 4 == 3) ? "R10 random gaps" : "R6 random");
        end
        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R7 every add produced one done", 64'(sb.size()), 64'd0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule